// File: doc/BRIEF.md
# Load/Store Data Alignment Unit

This combinational unit sits between a core's memory pipeline stage and a 64-bit data memory port. It adds a sign-extended immediate offset to a base address to form the effective address. It then decodes a six-bit memory opcode that names the access size and, for loads, the extension rule. On a store it moves the store operand onto the byte lanes picked by the low three address bits and raises the matching byte enables. On a load it takes the addressed field out of the 64-bit read word and extends it to 64 bits.

The unit checks every access against its natural alignment. It also rejects opcodes it does not know. In both cases it suppresses the memory strobes, so nothing in memory changes and no register is written.

Top module: `ldst_align`

## Requirements
- R1: `eff_addr` equals `base_addr` plus `imm_off` sign-extended to `ADDR_W` bits, modulo 2^ADDR_W, for every opcode.
- R2: For store opcodes 32, 33, 34 and 35 (1, 2, 4 and 8 bytes), when the access is aligned, `wr_en` is 1 and `byte_en` is the size mask (0x01, 0x03, 0x0F, 0xFF) shifted left by `eff_addr[2:0]`. Bit i of `byte_en` covers data bits 8i+7..8i.
- R3: On an aligned store, `wr_data` is `st_data` shifted left by 8*`eff_addr[2:0]` bits.
- R4: Load opcode 0 returns the addressed byte and opcode 1 returns the addressed halfword, each sign-extended to 64 bits. The field starts at bit 8*`eff_addr[2:0]` of `rd_data`.
- R5: Load opcode 4 returns the addressed byte and opcode 5 returns the addressed halfword, each zero-extended.
- R6: Load opcode 2 returns the addressed 32-bit word sign-extended. Opcode 6 returns the same word zero-extended.
- R7: Load opcode 3 at an address with `eff_addr[2:0]`=0 returns `rd_data` unchanged.
- R8: A legal access with `eff_addr` not a multiple of its size sets `misaligned`. It also forces `byte_en`, `wr_en`, `rd_en` and `ld_result` to zero.
- R9: Any opcode outside {0..6, 32..35} sets `illegal` and forces `rd_en`, `wr_en`, `byte_en`, `ld_result` and `misaligned` to zero.
- R10: An aligned load sets `rd_en` with `wr_en`=0 and `byte_en`=0. Whenever `rd_en` is 0, `ld_result` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_code | input | 6 | Memory opcode |
| base_addr | input | ADDR_W | Base register value |
| imm_off | input | OFF_W | Signed immediate offset |
| st_data | input | 64 | Store operand, right-aligned |
| rd_data | input | 64 | Read word returned by memory |
| eff_addr | output | ADDR_W | Effective address |
| rd_en | output | 1 | Aligned legal load |
| wr_en | output | 1 | Aligned legal store |
| byte_en | output | 8 | Store byte-lane enables |
| wr_data | output | 64 | Store data on its lanes |
| ld_result | output | 64 | Extended load value |
| misaligned | output | 1 | Access not aligned to its size |
| illegal | output | 1 | Unknown opcode |

## Verification
The address adder and the alignment check act in the same evaluation, because alignment is judged on the sum and not on the base. The bench sets this up with an aligned base and an odd offset, which must raise `misaligned`. It also uses an unaligned base that a matching offset repairs, which must yield a normal access with correct lanes. Expected enables and data are derived from the summed address the bench computes for itself.

// File: rtl/ldst_align.sv
module ldst_align #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16
) (
  input  logic [5:0]        op_code,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [OFF_W-1:0]  imm_off,
  input  logic [63:0]       st_data,
  input  logic [63:0]       rd_data,
  output logic [ADDR_W-1:0] eff_addr,
  output logic              rd_en,
  output logic              wr_en,
  output logic [7:0]        byte_en,
  output logic [63:0]       wr_data,
  output logic [63:0]       ld_result,
  output logic              misaligned,
  output logic              illegal
);
  localparam int EXT_W = ADDR_W - OFF_W;

  logic       is_load, is_store, legal, zext;
  logic [1:0] size_lg;
  logic [2:0] lane, align_bits;
  logic [7:0] size_mask;
  logic [63:0] shifted, extended;

  assign eff_addr = base_addr + {{EXT_W{imm_off[OFF_W-1]}}, imm_off};
  assign lane     = eff_addr[2:0];

  assign is_load  = (op_code <= 6'd6);
  assign is_store = (op_code >= 6'd32) && (op_code <= 6'd35);
  assign legal    = is_load || is_store;
  assign illegal  = !legal;
  assign size_lg  = op_code[1:0];
  assign zext     = op_code[2];

  always_comb begin
    case (size_lg)
      2'd0: begin size_mask = 8'h01; align_bits = 3'b000; end
      2'd1: begin size_mask = 8'h03; align_bits = 3'b001; end
      2'd2: begin size_mask = 8'h0F; align_bits = 3'b011; end
      default: begin size_mask = 8'hFF; align_bits = 3'b111; end
    endcase
  end

  assign misaligned = legal && ((lane & align_bits) != 3'b000);
  assign rd_en      = is_load && !misaligned;
  assign wr_en      = is_store && !misaligned;

  assign byte_en = wr_en ? (size_mask << lane) : 8'h00;
  assign wr_data = wr_en ? (st_data << {lane, 3'b000}) : 64'h0;

  assign shifted = rd_data >> {lane, 3'b000};

  always_comb begin
    case (size_lg)
      2'd0: extended = {{56{!zext && shifted[7]}},  shifted[7:0]};
      2'd1: extended = {{48{!zext && shifted[15]}}, shifted[15:0]};
      2'd2: extended = {{32{!zext && shifted[31]}}, shifted[31:0]};
      default: extended = shifted;
    endcase
  end

  assign ld_result = rd_en ? extended : 64'h0;
endmodule

module ldst_align_chk #(
  parameter int ADDR_W = 32
) (
  input logic [ADDR_W-1:0] eff_addr,
  input logic              rd_en,
  input logic              wr_en,
  input logic [7:0]        byte_en,
  input logic [63:0]       ld_result,
  input logic              misaligned,
  input logic              illegal
);
  always_comb begin
    p_quiet_when_misaligned_r8: assert (!misaligned || (byte_en == 8'h00 && !rd_en && !wr_en));
    p_quiet_when_illegal_r9: assert (!illegal || (!rd_en && !wr_en && !misaligned && byte_en == 8'h00));
    p_read_write_exclusive_r10: assert (!(rd_en && wr_en));
    p_zero_result_idle_r10: assert (rd_en || ld_result == 64'h0);
    p_enable_count_r2: assert (!wr_en || $countones(byte_en) inside {1, 2, 4, 8});
    p_first_lane_set_r2: assert (!wr_en || byte_en[eff_addr[2:0]]);
    p_no_enables_on_load_r10: assert (!rd_en || byte_en == 8'h00);
  end
endmodule

bind ldst_align ldst_align_chk #(.ADDR_W(ADDR_W)) u_chk (
  .eff_addr(eff_addr), .rd_en(rd_en), .wr_en(wr_en), .byte_en(byte_en),
  .ld_result(ld_result), .misaligned(misaligned), .illegal(illegal)
);

// File: tb/ldst_align_tb.sv
module ldst_align_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [5:0]  op_code;
  logic [31:0] base_addr;
  logic [15:0] imm_off;
  logic [63:0] st_data, rd_data;
  logic [31:0] eff_addr;
  logic        rd_en, wr_en, misaligned, illegal;
  logic [7:0]  byte_en;
  logic [63:0] wr_data, ld_result;

  int checks = 0, failures = 0;

  ldst_align #(.ADDR_W(32), .OFF_W(16)) u_dut (
    .op_code(op_code), .base_addr(base_addr), .imm_off(imm_off),
    .st_data(st_data), .rd_data(rd_data), .eff_addr(eff_addr),
    .rd_en(rd_en), .wr_en(wr_en), .byte_en(byte_en), .wr_data(wr_data),
    .ld_result(ld_result), .misaligned(misaligned), .illegal(illegal)
  );

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(logic [5:0] op, logic [31:0] b, logic [15:0] o,
                       logic [63:0] sd, logic [63:0] rd);
    @(posedge clk);
    #1;
    op_code = op; base_addr = b; imm_off = o; st_data = sd; rd_data = rd;
    #3;
  endtask

  task automatic t_reset_idle();
    drive(6'd7, 32'h0, 16'h0, 64'h0, 64'h0);
    chk("R9", "idle illegal", illegal, 1);
    chk("R9", "idle rd_en", rd_en, 0);
    chk("R9", "idle wr_en", wr_en, 0);
    chk("R9", "idle byte_en", byte_en, 0);
  endtask

  task automatic t_address();
    drive(6'd2, 32'h0000_1000, 16'hFFF8, 64'h0, 64'h0);
    chk("R1", "negative offset", eff_addr, 32'h0000_0FF8);
    drive(6'd0, 32'h0000_0001, 16'h7FFF, 64'h0, 64'h0);
    chk("R1", "max offset", eff_addr, 32'h0000_8000);
    drive(6'd3, 32'hFFFF_FFF0, 16'h0020, 64'h0, 64'h0);
    chk("R1", "wraparound", eff_addr, 32'h0000_0010);
  endtask

  task automatic t_store();
    drive(6'd32, 32'h100, 16'h5, 64'h0000_0000_0000_00AB, 64'h0);
    chk("R2", "byte enables", byte_en, 8'h20);
    chk("R2", "byte wr_en", wr_en, 1);
    chk("R3", "byte data", wr_data, 64'h0000_AB00_0000_0000);
    drive(6'd33, 32'h106, 16'h0, 64'h0000_0000_0000_1234, 64'h0);
    chk("R2", "half enables", byte_en, 8'hC0);
    chk("R3", "half data", wr_data, 64'h1234_0000_0000_0000);
    drive(6'd34, 32'h100, 16'h4, 64'h0000_0000_DEAD_BEEF, 64'h0);
    chk("R2", "word enables", byte_en, 8'hF0);
    chk("R3", "word data", wr_data, 64'hDEAD_BEEF_0000_0000);
    drive(6'd35, 32'h108, 16'h0, 64'h0123_4567_89AB_CDEF, 64'h0);
    chk("R2", "dword enables", byte_en, 8'hFF);
    chk("R3", "dword data", wr_data, 64'h0123_4567_89AB_CDEF);
    chk("R10", "store ld_result", ld_result, 0);
    chk("R10", "store rd_en", rd_en, 0);
  endtask

  task automatic t_load();
    logic [63:0] w = 64'hF1E2_D3C4_B5A6_9788;
    drive(6'd0, 32'h200, 16'h1, 64'h0, w);
    chk("R4", "signed byte", ld_result, 64'hFFFF_FFFF_FFFF_FF97);
    chk("R10", "load rd_en", rd_en, 1);
    chk("R10", "load byte_en", byte_en, 0);
    chk("R10", "load wr_en", wr_en, 0);
    drive(6'd4, 32'h200, 16'h1, 64'h0, w);
    chk("R5", "unsigned byte", ld_result, 64'h97);
    drive(6'd1, 32'h206, 16'h0, 64'h0, w);
    chk("R4", "signed half", ld_result, 64'hFFFF_FFFF_FFFF_F1E2);
    drive(6'd5, 32'h206, 16'h0, 64'h0, w);
    chk("R5", "unsigned half", ld_result, 64'hF1E2);
    drive(6'd0, 32'h202, 16'h0, 64'h0, 64'h0000_0000_0042_0000);
    chk("R4", "positive byte", ld_result, 64'h42);
    drive(6'd2, 32'h204, 16'h0, 64'h0, w);
    chk("R6", "signed word", ld_result, 64'hFFFF_FFFF_F1E2_D3C4);
    drive(6'd6, 32'h204, 16'h0, 64'h0, w);
    chk("R6", "unsigned word", ld_result, 64'h0000_0000_F1E2_D3C4);
    drive(6'd2, 32'h200, 16'h0, 64'h0, 64'h1122_3344_5566_7788);
    chk("R6", "positive word", ld_result, 64'h5566_7788);
    drive(6'd3, 32'h1F8, 16'h8, 64'h0, w);
    chk("R7", "doubleword", ld_result, w);
  endtask

  task automatic t_misaligned();
    drive(6'd33, 32'h300, 16'h1, 64'hFFFF, 64'h0);
    chk("R8", "half flag", misaligned, 1);
    chk("R8", "half byte_en", byte_en, 0);
    chk("R8", "half wr_en", wr_en, 0);
    drive(6'd34, 32'h302, 16'h0, 64'hFFFF, 64'h0);
    chk("R8", "word flag", misaligned, 1);
    drive(6'd35, 32'h304, 16'h0, 64'hFFFF, 64'h0);
    chk("R8", "dword flag", misaligned, 1);
    chk("R8", "dword byte_en", byte_en, 0);
    drive(6'd1, 32'h303, 16'h0, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R8", "load flag", misaligned, 1);
    chk("R8", "load rd_en", rd_en, 0);
    chk("R8", "load result", ld_result, 0);
    drive(6'd34, 32'h1003, 16'h1, 64'h0000_0000_CAFE_F00D, 64'h0);
    chk("R8", "repaired by offset", misaligned, 0);
    chk("R2", "repaired enables", byte_en, 8'hF0);
    chk("R3", "repaired data", wr_data, 64'hCAFE_F00D_0000_0000);
    drive(6'd32, 32'h307, 16'h0, 64'h5A, 64'h0);
    chk("R8", "byte never misaligned", misaligned, 0);
    chk("R2", "top lane", byte_en, 8'h80);
  endtask

  task automatic t_illegal();
    foreach (ill_ops[i]) begin
      drive(ill_ops[i], 32'h400, 16'h1, 64'hFF, 64'hFFFF_FFFF_FFFF_FFFF);
      chk("R9", "illegal flag", illegal, 1);
      chk("R9", "illegal misaligned", misaligned, 0);
      chk("R9", "illegal enables", {rd_en, wr_en, byte_en}, 0);
      chk("R9", "illegal result", ld_result, 0);
    end
    drive(6'd35, 32'h400, 16'h0, 64'h0, 64'h0);
    chk("R9", "legal store not flagged", illegal, 0);
  endtask

  logic [5:0] ill_ops [4] = '{6'd7, 6'd31, 6'd36, 6'd63};

  initial begin
    op_code = 6'd7; base_addr = '0; imm_off = '0; st_data = '0; rd_data = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset_idle();
    t_address();
    t_store();
    t_load();
    t_misaligned();
    t_illegal();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule